// File: doc/BRIEF.md
# Interrupt Context Stack Saver

This block is the part of an interrupt entry sequence that preserves the interrupted context. When the core acknowledges an interrupt, the block captures the 20-bit program counter, the 12-bit flag word and the stack pointer it selects. It then writes that context into a byte-wide stack memory, one byte per clock, over four consecutive cycles. The pointer grows downward.

The pointer choice depends on the kind of interrupt. A software interrupt whose number lies from 32 to 63 uses the user stack pointer when the user-flag bit is set, and the interrupt stack pointer when it is clear. Every other interrupt uses the interrupt stack pointer.

Once the fourth byte is written, the block pulses a done strobe. In that same cycle it issues a write-back of the selected pointer, lowered by four. The pointer that was not selected is never written.

Top module: `ctx_stack_saver`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the outputs `mem_we_o`, `done_o`, `usp_wr_o` and `isp_wr_o` are low. The block then waits idle for an acknowledge.
- R2: An acknowledge sampled at a clock edge while idle starts four byte writes. They come on the four cycles directly after that edge, to addresses P-1, P-2, P-3 and P-4 in that order, where P is the selected pointer at acknowledge.
- R3: The byte layout on the stack is as follows. P-1 receives {flag[11:8], pc[19:16]}, with the flag nibble in bits 7:4 and the PC nibble in bits 3:0. P-2 receives flag[7:0]. P-3 receives pc[15:8]. P-4 receives pc[7:0].
- R4: The user stack pointer is selected only when three conditions hold: `swi_valid_i` is high, `swi_num_i` lies from 32 to 63 inclusive, and `uflag_i` is 1. In every other case the interrupt stack pointer is selected.
- R5: `done_o` is high for exactly one cycle, the cycle after the fourth write. In that cycle the write strobe of the selected pointer is high, the other strobe stays low, and `sp_next_o` equals P-4.
- R6: PC, flag, user flag, interrupt number and both pointers are sampled only at the acknowledging edge. Changes to them during the save do not alter the written bytes, the addresses or the write-back.
- R7: An acknowledge that arrives during the four write cycles or the done cycle is ignored. It produces no additional writes and no second done pulse.
- R8: Address arithmetic wraps modulo 2^AW. A pointer of 2 writes to 1, 0, all-ones and all-ones minus 1, and writes back all-ones minus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| swi_valid_i | input | 1 | High when the interrupt is a software interrupt |
| swi_num_i | input | NW | Software interrupt number |
| pc_i | input | 20 | Current program counter |
| flg_i | input | 12 | Current flag context; bits 11:8 hold the priority level |
| uflag_i | input | 1 | User-flag bit |
| usp_i | input | AW | User stack pointer |
| isp_i | input | AW | Interrupt stack pointer |
| mem_addr_o | output | AW | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| mem_we_o | output | 1 | Stack byte write enable |
| sp_next_o | output | AW | New value for the selected pointer |
| usp_wr_o | output | 1 | Load `sp_next_o` into the user stack pointer |
| isp_wr_o | output | 1 | Load `sp_next_o` into the interrupt stack pointer |
| done_o | output | 1 | One-cycle save-complete pulse |

## Verification
The bench relies on a fixed result schedule. For an acknowledge seen at edge E, the four byte writes appear in the cycles after E, E+1, E+2 and E+3, and the done pulse and pointer write-back follow after E+4. The bench drives every stimulus on the falling edge and samples on each following falling edge. Each sample therefore checks exactly one of these cycles, and one further cycle confirms that the outputs are quiet again. The capture and busy-acknowledge scenarios change inputs, or pulse the acknowledge, inside this window and then compare against the schedule computed from the values present at E.

// File: rtl/ctx_stack_saver.sv
module ctx_stack_saver #(
  parameter int AW     = 16,
  parameter int NW     = 8,
  parameter int SWI_LO = 32,
  parameter int SWI_HI = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_i,
  input  logic          swi_valid_i,
  input  logic [NW-1:0] swi_num_i,
  input  logic [19:0]   pc_i,
  input  logic [11:0]   flg_i,
  input  logic          uflag_i,
  input  logic [AW-1:0] usp_i,
  input  logic [AW-1:0] isp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  output logic [AW-1:0] sp_next_o,
  output logic          usp_wr_o,
  output logic          isp_wr_o,
  output logic          done_o
);

  localparam int           NBYTES = 4;
  localparam logic [NW:0]  LO_X   = (NW+1)'(SWI_LO);
  localparam logic [NW:0]  HI_X   = (NW+1)'(SWI_HI);

  typedef enum logic [2:0] {S_IDLE, S_W1, S_W2, S_W3, S_W4, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] sp_q;
  logic [19:0]   pc_q;
  logic [11:0]   flg_q;
  logic          use_usp_q;

  logic [NW:0] num_x;
  logic        in_range, pick_usp, start;

  assign num_x    = {1'b0, swi_num_i};
  assign in_range = swi_valid_i && (num_x >= LO_X) && (num_x <= HI_X);
  assign pick_usp = in_range && uflag_i;
  assign start    = (state == S_IDLE) && ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      sp_q      <= '0;
      pc_q      <= '0;
      flg_q     <= '0;
      use_usp_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_W1;
          sp_q      <= pick_usp ? usp_i : isp_i;
          pc_q      <= pc_i;
          flg_q     <= flg_i;
          use_usp_q <= pick_usp;
        end
        S_W1:    state <= S_W2;
        S_W2:    state <= S_W3;
        S_W3:    state <= S_W4;
        S_W4:    state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] step;
  logic [7:0]    byte_sel;

  always_comb begin
    step     = '0;
    byte_sel = '0;
    case (state)
      S_W1: begin step = AW'(1); byte_sel = {flg_q[11:8], pc_q[19:16]}; end
      S_W2: begin step = AW'(2); byte_sel = flg_q[7:0];                 end
      S_W3: begin step = AW'(3); byte_sel = pc_q[15:8];                 end
      S_W4: begin step = AW'(4); byte_sel = pc_q[7:0];                  end
      default: ;
    endcase
  end

  assign mem_we_o    = (state == S_W1) || (state == S_W2) ||
                       (state == S_W3) || (state == S_W4);
  assign mem_addr_o  = sp_q - step;
  assign mem_wdata_o = byte_sel;
  assign done_o      = (state == S_DONE);
  assign sp_next_o   = sp_q - AW'(NBYTES);
  assign usp_wr_o    = done_o && use_usp_q;
  assign isp_wr_o    = done_o && !use_usp_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_we_o && !done_o && !usp_wr_o && !isp_wr_o));

  // R2
  write_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_o) |-> $past(ack_i));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - AW'(1)));

  // R5
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(mem_we_o) && !mem_we_o));

  // R5
  writeback_value_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sp_next_o == $past(mem_addr_o)));

  // R5
  one_pointer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({usp_wr_o, isp_wr_o}) && ((usp_wr_o || isp_wr_o) == done_o));

  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: tb/sim_ctx_stack_saver.sv
module sim_ctx_stack_saver;
  localparam int AW = 16;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ack_i = 1'b0;
  logic          swi_valid_i = 1'b0;
  logic [NW-1:0] swi_num_i = '0;
  logic [19:0]   pc_i = '0;
  logic [11:0]   flg_i = '0;
  logic          uflag_i = 1'b0;
  logic [AW-1:0] usp_i = '0;
  logic [AW-1:0] isp_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic          mem_we_o;
  logic [AW-1:0] sp_next_o;
  logic          usp_wr_o;
  logic          isp_wr_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  ctx_stack_saver #(.AW(AW), .NW(NW)) u0 (
    .clk(clk), .rst(rst), .ack_i(ack_i), .swi_valid_i(swi_valid_i),
    .swi_num_i(swi_num_i), .pc_i(pc_i), .flg_i(flg_i), .uflag_i(uflag_i),
    .usp_i(usp_i), .isp_i(isp_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .sp_next_o(sp_next_o),
    .usp_wr_o(usp_wr_o), .isp_wr_o(isp_wr_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_save(input logic [19:0] pc, input logic [11:0] flg,
                          input logic uf, input logic sv, input logic [NW-1:0] num,
                          input logic [AW-1:0] usp, input logic [AW-1:0] isp,
                          input bit mutate, input bit busy_ack, input string tag);
    logic          exp_u;
    logic [AW-1:0] p;
    logic [7:0]    b [4];
    exp_u = sv && (num >= 32) && (num <= 63) && uf;
    p     = exp_u ? usp : isp;
    b[0]  = {flg[11:8], pc[19:16]};
    b[1]  = flg[7:0];
    b[2]  = pc[15:8];
    b[3]  = pc[7:0];
    @(negedge clk);
    pc_i = pc; flg_i = flg; uflag_i = uf; swi_valid_i = sv; swi_num_i = num;
    usp_i = usp; isp_i = isp; ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    if (mutate) begin
      pc_i = ~pc; flg_i = ~flg; uflag_i = ~uf; swi_valid_i = ~sv;
      swi_num_i = num ^ 8'h20; usp_i = usp + 16'h100; isp_i = isp + 16'h200;
    end
    for (int i = 0; i < 4; i++) begin
      chk(mem_we_o === 1'b1, {"R2 we ", tag}, 32'(mem_we_o), 1);
      chk(mem_addr_o === p - AW'(i + 1), {"R2 addr ", tag}, 32'(mem_addr_o),
          32'(p - AW'(i + 1)));
      chk(mem_wdata_o === b[i], {"R3 data ", tag}, 32'(mem_wdata_o), 32'(b[i]));
      if (mutate)
        chk(mem_wdata_o === b[i], {"R6 captured data ", tag}, 32'(mem_wdata_o),
            32'(b[i]));
      chk(done_o === 1'b0, {"R5 early done ", tag}, 32'(done_o), 0);
      if (busy_ack) ack_i = (i == 1) || (i == 3);
      @(negedge clk);
    end
    chk(done_o === 1'b1, {"R5 done ", tag}, 32'(done_o), 1);
    chk(mem_we_o === 1'b0, {"R5 we off ", tag}, 32'(mem_we_o), 0);
    chk(usp_wr_o === exp_u, {"R4 usp select ", tag}, 32'(usp_wr_o), 32'(exp_u));
    chk(isp_wr_o === !exp_u, {"R4 isp select ", tag}, 32'(isp_wr_o), 32'(!exp_u));
    chk(sp_next_o === p - AW'(4), {"R5 sp_next ", tag}, 32'(sp_next_o),
        32'(p - AW'(4)));
    if (busy_ack) ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(done_o === 1'b0, {"R7 single done ", tag}, 32'(done_o), 0);
    chk(mem_we_o === 1'b0, {"R7 no extra write ", tag}, 32'(mem_we_o), 0);
    chk(!usp_wr_o && !isp_wr_o, {"R5 strobes off ", tag},
        32'({usp_wr_o, isp_wr_o}), 0);
    @(negedge clk);
    chk(mem_we_o === 1'b0, {"R7 still idle ", tag}, 32'(mem_we_o), 0);
    if (mutate) begin
      pc_i = '0; flg_i = '0; uflag_i = 0; swi_valid_i = 0; swi_num_i = '0;
    end
  endtask

  task automatic t_reset;
    chk(!mem_we_o && !done_o && !usp_wr_o && !isp_wr_o, "R1 reset outputs",
        32'({mem_we_o, done_o, usp_wr_o, isp_wr_o}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_we_o && !done_o, "R1 idle after reset", 32'({mem_we_o, done_o}), 0);
  endtask

  task automatic t_hw_irq;
    run_save(20'hA5C3E, 12'h7B1, 1'b1, 1'b0, 8'd40, 16'h4000, 16'h8000, 0, 0,
             "R4 hw irq");
  endtask

  task automatic t_swi_user;
    run_save(20'h12345, 12'hF0F, 1'b1, 1'b1, 8'd40, 16'h4000, 16'h8000, 0, 0,
             "R4 swi user");
  endtask

  task automatic t_swi_uflag0;
    run_save(20'hFEDCB, 12'h3A5, 1'b0, 1'b1, 8'd33, 16'h4000, 16'h8000, 0, 0,
             "R4 swi uflag0");
  endtask

  task automatic t_swi_bounds;
    run_save(20'h0F0F0, 12'h111, 1'b1, 1'b1, 8'd32, 16'h2222, 16'h9999, 0, 0, "R4 num32");
    run_save(20'h0F0F1, 12'h222, 1'b1, 1'b1, 8'd63, 16'h2222, 16'h9999, 0, 0, "R4 num63");
    run_save(20'h0F0F2, 12'h333, 1'b1, 1'b1, 8'd31, 16'h2222, 16'h9999, 0, 0, "R4 num31");
    run_save(20'h0F0F3, 12'h444, 1'b1, 1'b1, 8'd64, 16'h2222, 16'h9999, 0, 0, "R4 num64");
  endtask

  task automatic t_capture;
    run_save(20'h9ABCD, 12'hC3C, 1'b1, 1'b1, 8'd50, 16'h3000, 16'h7000, 1, 0,
             "R6 capture");
  endtask

  task automatic t_busy_ack;
    run_save(20'h55AA5, 12'h5A5, 1'b0, 1'b0, 8'd0, 16'h1234, 16'h6000, 0, 1,
             "R7 busy ack");
  endtask

  task automatic t_wrap;
    run_save(20'h00001, 12'h800, 1'b0, 1'b0, 8'd0, 16'h5000, 16'h0002, 0, 0,
             "R8 wrap");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_hw_irq();
        t_swi_user();
        t_swi_uflag0();
        t_swi_bounds();
        t_capture();
        t_busy_ack();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule